// File: doc/BRIEF.md
# Target Read Prefetch Buffer Manager

This block sits on the target read path of a bus bridge and manages the data fetched ahead of an external master's delayed read. For each incoming read it decides whether prefetch is allowed. The decision uses the base-address window that was hit, the read command and two control bits. When prefetch is allowed, the block asks the internal bus for the whole 32-byte line that holds the requested word. Once that line is complete, it asks for the following line as well. The two lines are kept in two line-sized buffers.

Each later beat of a burst is looked up in three places: the delayed-request word and the two buffers. The block answers one cycle later with either data or a disconnect. A disconnect never starts a new fetch.

Any posted memory write, in either direction, throws away all prefetched data. So does the prefetch-disable bit going high. The word the master actually asked for is kept, because it is not prefetch data.

Top module: `pf_read_buf_mgr`

## Requirements
- R1: A request prefetches only if its window index is 1 to 5. It must also either have `pf_dis_i` low with command code 2'b10 (read-multiple), or have `pf_force_i` high. If it prefetches, the cycle after the request shows `fetch_req_o` high for one cycle, `fetch_addr_o` set to the request address with bits [4:0] cleared, and `fetch_buf_o` = 0.
- R2: A request on window 0 or on an index of 6 or more never fetches. A request with another command while `pf_force_i` is low never fetches. A request with `pf_dis_i` high while `pf_force_i` is low never fetches.
- R3: A line buffer reports a hit only after all 8 of its word indices have been written. Until then, beats to that line miss, except for the delayed-request word (R4).
- R4: The requested word (address bits [31:2]) hits as soon as fill data for its index has been written into the first buffer. It still hits after an invalidation. The next request drops it.
- R5: When the first buffer completes with no invalidation in that cycle, the next cycle shows `fetch_req_o` high with `fetch_addr_o` = line address + 32 and `fetch_buf_o` = 1. Later fill words go to the second buffer.
- R6: The following events invalidate: `tgt_wr_post_i` high, `ini_wr_post_i` high, or `pf_dis_i` going from 0 to 1. An invalidation clears both buffers and ends any fill in progress. Fill words after it are ignored, and no look-ahead fetch follows.
- R7: If an invalidation and a fill word arrive in the same cycle, the fill word is discarded. This holds even if it carries the delayed-request word.
- R8: A beat that misses everywhere gives `rsp_valid_o` = 1, `rsp_hit_o` = 0 and `disconnect_o` = 1 in the next cycle, and it causes no fetch request.
- R9: A beat that hits gives `rsp_valid_o` = 1, `rsp_hit_o` = 1, `disconnect_o` = 0 and the stored word on `rsp_data_o` in the next cycle.
- R10: After reset, `fetch_req_o`, `rsp_valid_o` and `disconnect_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | New delayed read request latched this cycle |
| req_win_i | input | 3 | Index of the base-address window hit |
| req_cmd_i | input | 2 | Read command code, 2'b10 = read-multiple |
| req_addr_i | input | 32 | Byte address of the requested word |
| pf_dis_i | input | 1 | Prefetch-disable control bit |
| pf_force_i | input | 1 | Prefetch-force control bit |
| tgt_wr_post_i | input | 1 | Memory write posted in the target direction |
| ini_wr_post_i | input | 1 | Memory write posted toward the external bus |
| fill_valid_i | input | 1 | Fill word from the internal bus |
| fill_idx_i | input | 3 | Word index of the fill within its line |
| fill_data_i | input | 32 | Fill word data |
| beat_valid_i | input | 1 | Burst beat lookup |
| beat_addr_i | input | 32 | Byte address of the beat |
| fetch_req_o | output | 1 | Line fetch request pulse |
| fetch_addr_o | output | 32 | Line-aligned address to fetch |
| fetch_buf_o | output | 1 | Destination buffer of the fetch |
| rsp_valid_o | output | 1 | Lookup answer valid |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_data_o | output | 32 | Data for a hit |
| disconnect_o | output | 1 | Beat missed, disconnect without data |

## Verification
The hardest situations to reach from the ports are the ones where an invalidation lands in the middle of a fill. One case is a posted write arriving in exactly the cycle that delivers the delayed-request word. Another is the disable bit rising while the look-ahead buffer is only partly written. The stimulus reaches both by writing fill words one per cycle, out of index order, and pulsing the invalidating input at a chosen word. It then keeps supplying the rest of the line. Beat lookups afterwards show that the line never became valid, that no look-ahead fetch appeared, and whether the requested word survived.

// File: rtl/pf_pkg.sv
package pf_pkg;

  typedef enum logic [1:0] {
    CMD_READ      = 2'b00,
    CMD_READ_LINE = 2'b01,
    CMD_READ_MULT = 2'b10,
    CMD_RSVD      = 2'b11
  } rd_cmd_e;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'b00,
    FS_LINE  = 2'b01,
    FS_AHEAD = 2'b10
  } fill_state_e;

endpackage

// File: rtl/pf_qualify.sv
module pf_qualify
  import pf_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int WIN_W   = 3
) (
  input  logic [WIN_W-1:0] win_i,
  input  logic [1:0]       cmd_i,
  input  logic             pf_dis_i,
  input  logic             pf_force_i,
  output logic             qual_o
);

  localparam int WIN_SPACE = 1 << WIN_W;

  logic [WIN_SPACE-1:0] pf_win_map;

  // window 0 is non-prefetchable; indices past NUM_WIN are no hit
  for (genvar w = 0; w < WIN_SPACE; w++) begin : g_map
    if (w == 0 || w >= NUM_WIN) begin : g_np
      assign pf_win_map[w] = 1'b0;
    end else begin : g_p
      assign pf_win_map[w] = 1'b1;
    end
  end

  logic cmd_mult;
  assign cmd_mult = (rd_cmd_e'(cmd_i) == CMD_READ_MULT);
  assign qual_o   = pf_win_map[win_i] & ((~pf_dis_i & cmd_mult) | pf_force_i);

endmodule

// File: rtl/pf_line_buf.sv
module pf_line_buf #(
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int TAG_W      = 27,
  parameter int IDX_W      = $clog2(LINE_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic [TAG_W-1:0]  start_tag_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  input  logic [IDX_W-1:0]  lk_idx_i,
  output logic              valid_o,
  output logic              hit_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              done_o
);

  logic [LINE_WORDS-1:0] mask_q;
  logic [TAG_W-1:0]      tag_q;
  logic [DATA_W-1:0]     mem_q [LINE_WORDS];
  logic [LINE_WORDS-1:0] wr_bit;
  logic                  wr_eff;

  assign wr_bit  = {{(LINE_WORDS-1){1'b0}}, 1'b1} << wr_idx_i;
  // clear beats start beats write
  assign wr_eff  = wr_en_i & ~clr_i & ~start_i;
  assign valid_o = &mask_q;
  assign done_o  = wr_eff & ~valid_o & (&(mask_q | wr_bit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      tag_q  <= '0;
    end else if (clr_i) begin
      mask_q <= '0;
    end else if (start_i) begin
      mask_q <= '0;
      tag_q  <= start_tag_i;
    end else if (wr_en_i) begin
      mask_q <= mask_q | wr_bit;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_eff) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign hit_o     = valid_o & (tag_q == lk_tag_i);
  assign rd_data_o = mem_q[lk_idx_i];

  p_clr_empties_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !valid_o);

  p_valid_needs_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(wr_en_i && !clr_i));

  p_start_empties_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !valid_o);

endmodule

// File: rtl/pf_fill_ctrl.sv
module pf_fill_ctrl
  import pf_pkg::*;
#(
  parameter int TAG_W = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_start_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic             inval_i,
  input  logic             done_line_i,
  input  logic             done_ahead_i,
  output logic             ahead_start_o,
  output logic [TAG_W-1:0] ahead_tag_o,
  output logic             line_fill_o,
  output logic             ahead_fill_o,
  output logic [TAG_W-1:0] line_tag_o,
  output logic             fetch_req_o,
  output logic [TAG_W-1:0] fetch_tag_o,
  output logic             fetch_buf_o
);

  fill_state_e      state_q;
  logic [TAG_W-1:0] line_q;

  assign line_fill_o   = (state_q == FS_LINE);
  assign ahead_fill_o  = (state_q == FS_AHEAD);
  assign line_tag_o    = line_q;
  assign ahead_tag_o   = line_q + TAG_W'(1);
  assign ahead_start_o = line_fill_o & done_line_i & ~inval_i & ~req_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= FS_IDLE;
      line_q      <= '0;
      fetch_req_o <= 1'b0;
      fetch_tag_o <= '0;
      fetch_buf_o <= 1'b0;
    end else begin
      fetch_req_o <= 1'b0;
      if (inval_i) begin
        state_q <= FS_IDLE;
      end else if (req_start_i) begin
        state_q     <= FS_LINE;
        line_q      <= req_tag_i;
        fetch_req_o <= 1'b1;
        fetch_tag_o <= req_tag_i;
        fetch_buf_o <= 1'b0;
      end else begin
        unique case (state_q)
          FS_LINE: if (ahead_start_o) begin
            state_q     <= FS_AHEAD;
            fetch_req_o <= 1'b1;
            fetch_tag_o <= ahead_tag_o;
            fetch_buf_o <= 1'b1;
          end
          FS_AHEAD: if (done_ahead_i) state_q <= FS_IDLE;
          default: state_q <= FS_IDLE;
        endcase
      end
    end
  end

  p_ahead_after_line_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && fetch_buf_o) |-> $past(state_q == FS_LINE && done_line_i));

  p_fetch_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> ($past(req_start_i) || $past(done_line_i)));

  p_inval_no_fetch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> !fetch_req_o);

  p_fetch_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && !fetch_buf_o) |=> !(fetch_req_o && !fetch_buf_o));

endmodule

// File: rtl/pf_read_buf_mgr.sv
module pf_read_buf_mgr
  import pf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int NUM_WIN    = 6,
  parameter int WIN_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [WIN_W-1:0]  req_win_i,
  input  logic [1:0]        req_cmd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              pf_dis_i,
  input  logic              pf_force_i,
  input  logic              tgt_wr_post_i,
  input  logic              ini_wr_post_i,
  input  logic              fill_valid_i,
  input  logic [$clog2(LINE_WORDS)-1:0] fill_idx_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              beat_valid_i,
  input  logic [ADDR_W-1:0] beat_addr_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              fetch_buf_o,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              disconnect_o
);

  localparam int NUM_BUF = 2;
  localparam int IDX_W   = $clog2(LINE_WORDS);
  localparam int BYTE_W  = $clog2(DATA_W / 8);
  localparam int OFF_W   = IDX_W + BYTE_W;
  localparam int TAG_W   = ADDR_W - OFF_W;
  localparam int WORD_W  = ADDR_W - BYTE_W;

  logic pf_dis_q;
  logic inval;
  logic qual;
  logic req_start;

  logic             ahead_start;
  logic [TAG_W-1:0] ahead_tag;
  logic             line_fill;
  logic             ahead_fill;
  logic [TAG_W-1:0] line_tag;
  logic [TAG_W-1:0] fetch_tag;

  logic [NUM_BUF-1:0] b_clr, b_start, b_wr, b_valid, b_hit, b_done;
  logic [TAG_W-1:0]   b_tag  [NUM_BUF];
  logic [DATA_W-1:0]  b_data [NUM_BUF];

  logic [WORD_W-1:0] dr_addr_q;
  logic              dr_valid_q;
  logic [DATA_W-1:0] dr_data_q;

  logic unused_low;
  assign unused_low = ^{req_addr_i[BYTE_W-1:0], beat_addr_i[BYTE_W-1:0], b_valid};

  // invalidation: posted write either way, or disable rising
  assign inval = tgt_wr_post_i | ini_wr_post_i | (pf_dis_i & ~pf_dis_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pf_dis_q <= 1'b0;
    else         pf_dis_q <= pf_dis_i;
  end

  pf_qualify #(
    .NUM_WIN (NUM_WIN),
    .WIN_W   (WIN_W)
  ) u_qual (
    .win_i      (req_win_i),
    .cmd_i      (req_cmd_i),
    .pf_dis_i   (pf_dis_i),
    .pf_force_i (pf_force_i),
    .qual_o     (qual)
  );

  assign req_start = req_valid_i & qual & ~inval;

  pf_fill_ctrl #(
    .TAG_W (TAG_W)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_start_i   (req_start),
    .req_tag_i     (req_addr_i[ADDR_W-1:OFF_W]),
    .inval_i       (inval),
    .done_line_i   (b_done[0]),
    .done_ahead_i  (b_done[1]),
    .ahead_start_o (ahead_start),
    .ahead_tag_o   (ahead_tag),
    .line_fill_o   (line_fill),
    .ahead_fill_o  (ahead_fill),
    .line_tag_o    (line_tag),
    .fetch_req_o   (fetch_req_o),
    .fetch_tag_o   (fetch_tag),
    .fetch_buf_o   (fetch_buf_o)
  );

  assign fetch_addr_o = {fetch_tag, {OFF_W{1'b0}}};

  // buffer 0 holds the requested line, buffer 1 the line ahead
  assign b_clr[0]   = inval;
  assign b_start[0] = req_start;
  assign b_tag[0]   = req_addr_i[ADDR_W-1:OFF_W];
  assign b_wr[0]    = fill_valid_i & line_fill;
  assign b_clr[1]   = inval | req_start;
  assign b_start[1] = ahead_start;
  assign b_tag[1]   = ahead_tag;
  assign b_wr[1]    = fill_valid_i & ahead_fill;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    pf_line_buf #(
      .DATA_W     (DATA_W),
      .LINE_WORDS (LINE_WORDS),
      .TAG_W      (TAG_W),
      .IDX_W      (IDX_W)
    ) u_buf (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (b_clr[b]),
      .start_i     (b_start[b]),
      .start_tag_i (b_tag[b]),
      .wr_en_i     (b_wr[b]),
      .wr_idx_i    (fill_idx_i),
      .wr_data_i   (fill_data_i),
      .lk_tag_i    (beat_addr_i[ADDR_W-1:OFF_W]),
      .lk_idx_i    (beat_addr_i[OFF_W-1:BYTE_W]),
      .valid_o     (b_valid[b]),
      .hit_o       (b_hit[b]),
      .rd_data_o   (b_data[b]),
      .done_o      (b_done[b])
    );
  end

  // delayed-request word: not prefetch data, survives invalidation
  logic dr_capture;
  assign dr_capture = b_wr[0] & ~inval & ~req_start &
                      ({line_tag, fill_idx_i} == dr_addr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dr_addr_q  <= '0;
      dr_valid_q <= 1'b0;
      dr_data_q  <= '0;
    end else if (req_valid_i) begin
      dr_addr_q  <= req_addr_i[ADDR_W-1:BYTE_W];
      dr_valid_q <= 1'b0;
    end else if (dr_capture) begin
      dr_valid_q <= 1'b1;
      dr_data_q  <= fill_data_i;
    end
  end

  logic              lk_hit;
  logic [DATA_W-1:0] lk_data;

  always_comb begin
    lk_hit  = 1'b0;
    lk_data = '0;
    for (int b = NUM_BUF - 1; b >= 0; b--) begin
      if (b_hit[b]) begin
        lk_hit  = 1'b1;
        lk_data = b_data[b];
      end
    end
    if (dr_valid_q && beat_addr_i[ADDR_W-1:BYTE_W] == dr_addr_q) begin
      lk_hit  = 1'b1;
      lk_data = dr_data_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_hit_o    <= 1'b0;
      rsp_data_o   <= '0;
      disconnect_o <= 1'b0;
    end else begin
      rsp_valid_o  <= beat_valid_i;
      rsp_hit_o    <= beat_valid_i & lk_hit;
      rsp_data_o   <= (beat_valid_i & lk_hit) ? lk_data : '0;
      disconnect_o <= beat_valid_i & ~lk_hit;
    end
  end

  p_disc_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disconnect_o |-> (rsp_valid_o && !rsp_hit_o));

  p_rsp_from_beat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(beat_valid_i));

  p_dr_survives_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dr_valid_q && !req_valid_i) |=> dr_valid_q);

  p_no_fetch_unqual_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !qual && !line_fill) |=> !fetch_req_o);

endmodule

// File: tb/sim_pf_read_buf_mgr.sv
module sim_pf_read_buf_mgr;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  req_win_i = '0;
  logic [1:0]  req_cmd_i = '0;
  logic [31:0] req_addr_i = '0;
  logic        pf_dis_i = 1'b0;
  logic        pf_force_i = 1'b0;
  logic        tgt_wr_post_i = 1'b0;
  logic        ini_wr_post_i = 1'b0;
  logic        fill_valid_i = 1'b0;
  logic [2:0]  fill_idx_i = '0;
  logic [31:0] fill_data_i = '0;
  logic        beat_valid_i = 1'b0;
  logic [31:0] beat_addr_i = '0;
  logic        fetch_req_o;
  logic [31:0] fetch_addr_o;
  logic        fetch_buf_o;
  logic        rsp_valid_o;
  logic        rsp_hit_o;
  logic [31:0] rsp_data_o;
  logic        disconnect_o;

  always #2 clk_i = ~clk_i;

  pf_read_buf_mgr u0 (.*);

  typedef struct {
    logic        hit;
    logic [31:0] data;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  function automatic logic [31:0] fd(logic [31:0] a);
    return a ^ 32'hC3C3_5A5A;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic fetch_chk(input bit exp_req, input logic [31:0] exp_addr,
                           input logic exp_buf, input string req);
    check(fetch_req_o == exp_req, req, {31'd0, fetch_req_o}, {31'd0, exp_req});
    if (exp_req) begin
      check(fetch_addr_o == exp_addr, req, fetch_addr_o, exp_addr);
      check(fetch_buf_o == exp_buf, req, {31'd0, fetch_buf_o}, {31'd0, exp_buf});
    end
  endtask

  task automatic do_req(input logic [2:0] win, input logic [1:0] cmd,
                        input logic [31:0] addr);
    req_valid_i = 1'b1; req_win_i = win; req_cmd_i = cmd; req_addr_i = addr;
    step();
    req_valid_i = 1'b0;
  endtask

  task automatic do_fill(input logic [31:0] base, input int idx);
    fill_valid_i = 1'b1;
    fill_idx_i   = idx[2:0];
    fill_data_i  = fd(base + 32'(idx * 4));
    step();
    fill_valid_i = 1'b0;
  endtask

  task automatic do_beat(input logic [31:0] addr, input logic hit,
                         input logic [31:0] data, input string req);
    exp_t e;
    e.hit = hit; e.data = data; e.req = req;
    exp_q.push_back(e);
    beat_valid_i = 1'b1; beat_addr_i = addr;
    step();
    beat_valid_i = 1'b0;
  endtask

  // monitor: answers arrive the cycle after each beat
  always @(negedge clk_i) begin
    if (rst_ni && rsp_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected response", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_hit_o == e.hit, e.req, {31'd0, rsp_hit_o}, {31'd0, e.hit});
        check(disconnect_o == !e.hit, e.req, {31'd0, disconnect_o}, {31'd0, !e.hit});
        if (e.hit) check(rsp_data_o == e.data, e.req, rsp_data_o, e.data);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R10 reset state
    check(fetch_req_o == 1'b0, "R10 fetch_req", {31'd0, fetch_req_o}, 32'd0);
    check(rsp_valid_o == 1'b0, "R10 rsp_valid", {31'd0, rsp_valid_o}, 32'd0);
    check(disconnect_o == 1'b0, "R10 disconnect", {31'd0, disconnect_o}, 32'd0);
    rst_ni = 1'b1;
    step();

    // R2 non-qualifying requests
    do_req(3'd0, 2'b10, 32'h0400_0000);
    fetch_chk(1'b0, '0, 1'b0, "R2 window 0 read-multiple");
    do_req(3'd3, 2'b01, 32'h0400_0000);
    fetch_chk(1'b0, '0, 1'b0, "R2 read-line no force");
    pf_force_i = 1'b1;
    do_req(3'd6, 2'b10, 32'h0400_0000);
    fetch_chk(1'b0, '0, 1'b0, "R2 window 6 forced");
    do_req(3'd0, 2'b00, 32'h0400_0000);
    fetch_chk(1'b0, '0, 1'b0, "R2 window 0 forced");
    pf_force_i = 1'b0;
    pf_dis_i = 1'b1;
    step();
    do_req(3'd3, 2'b10, 32'h0400_0000);
    fetch_chk(1'b0, '0, 1'b0, "R2 disabled read-multiple");
    pf_dis_i = 1'b0;
    step();

    // R1 qualifying request, R4 early delayed word, R3 partial line
    do_req(3'd2, 2'b10, 32'h1000_0048);
    fetch_chk(1'b1, 32'h1000_0040, 1'b0, "R1 line fetch");
    do_fill(32'h1000_0040, 2);
    fetch_chk(1'b0, '0, 1'b0, "R5 no early ahead");
    do_beat(32'h1000_0048, 1'b1, fd(32'h1000_0048), "R4 delayed word hit");
    do_beat(32'h1000_0044, 1'b0, '0, "R8 partial line miss");
    fetch_chk(1'b0, '0, 1'b0, "R8 miss no fetch");
    for (int i = 0; i < 7; i++) if (i != 2) do_fill(32'h1000_0040, i);
    do_beat(32'h1000_0040, 1'b0, '0, "R3 incomplete line miss");
    do_fill(32'h1000_0040, 7);
    fetch_chk(1'b1, 32'h1000_0060, 1'b1, "R5 ahead fetch");
    do_beat(32'h1000_0040, 1'b1, fd(32'h1000_0040), "R9 line hit word 0");
    do_beat(32'h1000_005C, 1'b1, fd(32'h1000_005C), "R9 line hit word 7");
    for (int i = 7; i >= 0; i--) do_fill(32'h1000_0060, i);
    fetch_chk(1'b0, '0, 1'b0, "R5 no third fetch");
    do_beat(32'h1000_007C, 1'b1, fd(32'h1000_007C), "R9 ahead buffer hit");
    do_beat(32'h1000_0064, 1'b1, fd(32'h1000_0064), "R9 ahead buffer hit");
    do_beat(32'h1000_0080, 1'b0, '0, "R8 beyond both lines");
    fetch_chk(1'b0, '0, 1'b0, "R8 miss no fetch");

    // R6 target write invalidates, R4 delayed word kept
    tgt_wr_post_i = 1'b1;
    step();
    tgt_wr_post_i = 1'b0;
    do_beat(32'h1000_0040, 1'b0, '0, "R6 buffer 0 cleared");
    do_beat(32'h1000_0060, 1'b0, '0, "R6 buffer 1 cleared");
    do_beat(32'h1000_0048, 1'b1, fd(32'h1000_0048), "R4 delayed word survives");

    // R1 force path, R7 fill dropped with invalidation
    pf_dis_i = 1'b1;
    step();
    pf_force_i = 1'b1;
    do_req(3'd5, 2'b00, 32'h3000_000C);
    fetch_chk(1'b1, 32'h3000_0000, 1'b0, "R1 forced fetch");
    pf_force_i = 1'b0;
    for (int i = 0; i < 3; i++) do_fill(32'h3000_0000, i);
    ini_wr_post_i = 1'b1;
    do_fill(32'h3000_0000, 3);
    ini_wr_post_i = 1'b0;
    for (int i = 4; i < 8; i++) do_fill(32'h3000_0000, i);
    fetch_chk(1'b0, '0, 1'b0, "R6 aborted fill no ahead");
    do_beat(32'h3000_000C, 1'b0, '0, "R7 dropped delayed word");
    do_beat(32'h3000_0000, 1'b0, '0, "R6 line never valid");

    // R6 disable rising during ahead fill
    pf_dis_i = 1'b0;
    step();
    do_req(3'd1, 2'b10, 32'h2000_0010);
    fetch_chk(1'b1, 32'h2000_0000, 1'b0, "R1 window 1 fetch");
    for (int i = 0; i < 8; i++) do_fill(32'h2000_0000, i);
    fetch_chk(1'b1, 32'h2000_0020, 1'b1, "R5 ahead fetch");
    do_fill(32'h2000_0020, 0);
    do_fill(32'h2000_0020, 1);
    pf_dis_i = 1'b1;
    step();
    do_beat(32'h2000_0000, 1'b0, '0, "R6 disable rise clears");
    do_beat(32'h2000_0010, 1'b1, fd(32'h2000_0010), "R4 delayed word kept");
    for (int i = 2; i < 8; i++) do_fill(32'h2000_0020, i);
    fetch_chk(1'b0, '0, 1'b0, "R6 no fetch after abort");
    do_beat(32'h2000_0020, 1'b0, '0, "R6 ahead line ignored");

    repeat (3) step();
    check(exp_q.size() == 0, "R9 all responses seen", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule